// File: doc/BRIEF.md
# Ranked Track Selector with Ghost Cancellation

This block takes in a fixed number of track candidates on every bunch crossing, one crossing per clock. Each candidate carries a valid flag, a rank (larger means more detector stations contributed) and two angular coordinates, azimuth and polar angle. It keeps the candidates of the two previous crossings, so decisions are made over a window of three crossings.

Inside that window every candidate is compared with every other candidate in the same clock. A candidate is removed as a duplicate ("ghost") when another candidate lies within programmable windows in both coordinates and takes precedence over it. From the survivors that have not been reported yet, the block reports the best three in order of precedence. A one-output mode reports only the single best survivor. Results are registered and appear one clock after the crossing that produced them. The block is placed after track assembly and before output multiplexing, and it does not compute ranks or coordinates.

Top module: `ghost_track_selector`

## Requirements
- R1: While rst_n is low at a clock edge, every out_valid bit is low after that edge and all stored crossings are emptied, so no earlier candidate can be reported after reset.
- R2: The outputs after a clock edge come from the crossing presented at that edge, together with the two stored crossings. Survivors are listed by precedence: a higher rank first; for equal ranks a newer crossing first; within one crossing a lower input index first.
- R3: Output slots are filled from slot 0 upward, and any slot without a candidate has its out_valid bit low.
- R4: A candidate is cancelled when another valid candidate in the window has |Δazimuth| ≤ win_phi and |Δpolar| ≤ win_theta and takes precedence over it. Both bounds are inclusive.
- R5: The precedence used for cancellation is the one of R2. When two close candidates have equal ranks, the one from the newer crossing survives. Within one crossing, the lower input index survives.
- R6: A candidate takes part in cancellation and selection in its own crossing and in the two crossings that follow. It can therefore be reported with age 0, 1 or 2. After that it is dropped.
- R7: A candidate that has been reported, or that has been cancelled, is never reported in a later crossing. While it stays in the window it still cancels close candidates that rank below it.
- R8: When mode_single is high, only slot 0 may be valid. Survivors that are not chosen stay eligible for later crossings.
- R9: For each valid slot, out_age gives the crossing (0 = current, 1 = one back, 2 = two back), out_idx gives the candidate's input position, and rank and coordinates are copied unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one crossing per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_single | input | 1 | 1: report one candidate; 0: report up to N_OUT |
| win_phi | input | PHI_W | Azimuth closeness window (inclusive) |
| win_theta | input | THETA_W | Polar closeness window (inclusive) |
| in_valid | input | N_CAND | Candidate valid flags, bit i is candidate i |
| in_rank | input | N_CAND*RANK_W | Candidate ranks, candidate i at bits i*RANK_W |
| in_phi | input | N_CAND*PHI_W | Candidate azimuth values |
| in_theta | input | N_CAND*THETA_W | Candidate polar values |
| out_valid | output | N_OUT | Slot valid flags |
| out_rank | output | N_OUT*RANK_W | Rank per slot |
| out_phi | output | N_OUT*PHI_W | Azimuth per slot |
| out_theta | output | N_OUT*THETA_W | Polar angle per slot |
| out_age | output | N_OUT*2 | Crossing age per slot |
| out_idx | output | N_OUT*$clog2(N_CAND) | Input index per slot |

## Verification
The bench applies several crossing patterns. Well-separated candidates in scrambled rank order check that sorting alone is correct. Pairs placed exactly on the window edge, and one count past it, show that the bounds are inclusive. Duplicates arrive in the same crossing and in later crossings; these tell a ghost of an already-reported track apart from a new track. Equal-rank duplicates, first in one crossing and then across two crossings, check both tie rules. Single-output runs followed by empty crossings show that candidates left over are reported later with their correct age and then dropped after two crossings. A full six-candidate crossing covers every input position.

// File: rtl/tsel_pkg.sv
// Shared definitions for the ranked track selector.
// Assumes: a pool position p maps to age p / N_CAND and index p % N_CAND,
// so a lower position is always a newer crossing or a lower index.
package tsel_pkg;
    localparam int unsigned CROSSINGS = 3;
    localparam int unsigned AGE_W     = 2;

    typedef enum logic [AGE_W-1:0] {
        AGE_NOW  = 2'd0,
        AGE_PREV = 2'd1,
        AGE_OLD  = 2'd2
    } age_e;
endpackage

// File: rtl/tsel_history.sv
// Candidate window: the current crossing (taken from the ports) plus
// CROSSINGS-1 stored crossings. It produces a flat pool ordered newest
// first, and a per-entry "done" flag that marks entries already reported
// or cancelled. Assumes retire_lo covers only the entries that move on.
module tsel_history
    import tsel_pkg::*;
#(
    parameter int N_CAND  = 6,
    parameter int RANK_W  = 6,
    parameter int PHI_W   = 8,
    parameter int THETA_W = 8
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic [N_CAND-1:0]                      cur_v,
    input  logic [N_CAND*RANK_W-1:0]               cur_r,
    input  logic [N_CAND*PHI_W-1:0]                cur_p,
    input  logic [N_CAND*THETA_W-1:0]              cur_t,
    input  logic [(CROSSINGS-1)*N_CAND-1:0]        retire_lo,
    output logic [CROSSINGS*N_CAND-1:0]            pool_v,
    output logic [CROSSINGS*N_CAND-1:0]            pool_done,
    output logic [CROSSINGS*N_CAND*RANK_W-1:0]     pool_r,
    output logic [CROSSINGS*N_CAND*PHI_W-1:0]      pool_p,
    output logic [CROSSINGS*N_CAND*THETA_W-1:0]    pool_t
);
    localparam int HN = (CROSSINGS - 1) * N_CAND;

    logic [HN-1:0]         h_v;
    logic [HN-1:0]         h_done;
    logic [HN*RANK_W-1:0]  h_r;
    logic [HN*PHI_W-1:0]   h_p;
    logic [HN*THETA_W-1:0] h_t;

    // Pool view: stored crossings above, current crossing at the bottom.
    assign pool_v    = {h_v, cur_v};
    assign pool_done = {h_done, {N_CAND{1'b0}}};
    assign pool_r    = {h_r, cur_r};
    assign pool_p    = {h_p, cur_p};
    assign pool_t    = {h_t, cur_t};

    // Shift the window by one crossing; the oldest crossing drops out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_v    <= '0;
            h_done <= '0;
            h_r    <= '0;
            h_p    <= '0;
            h_t    <= '0;
        end else begin
            h_v    <= pool_v[HN-1:0];
            h_done <= pool_done[HN-1:0] | retire_lo;
            h_r    <= pool_r[HN*RANK_W-1:0];
            h_p    <= pool_p[HN*PHI_W-1:0];
            h_t    <= pool_t[HN*THETA_W-1:0];
        end
    end
endmodule

// File: rtl/tsel_cancel.sv
// All-pairs ghost cancellation over the pool in one combinational step.
// Entry i is cancelled if some other valid entry j is within both windows
// and precedes it (higher rank, or equal rank at a lower pool position).
// Assumes cancelled and reported entries still act as cancellers.
module tsel_cancel #(
    parameter int P       = 18,
    parameter int RANK_W  = 6,
    parameter int PHI_W   = 8,
    parameter int THETA_W = 8
) (
    input  logic [P-1:0]          pool_v,
    input  logic [P*RANK_W-1:0]   pool_r,
    input  logic [P*PHI_W-1:0]    pool_p,
    input  logic [P*THETA_W-1:0]  pool_t,
    input  logic [PHI_W-1:0]      win_phi,
    input  logic [THETA_W-1:0]    win_theta,
    output logic [P-1:0]          alive
);
    // Absolute difference of two azimuth values.
    function automatic logic [PHI_W-1:0] dist_phi(input logic [PHI_W-1:0] a, input logic [PHI_W-1:0] b);
        return (a > b) ? a - b : b - a;
    endfunction

    // Absolute difference of two polar values.
    function automatic logic [THETA_W-1:0] dist_theta(input logic [THETA_W-1:0] a, input logic [THETA_W-1:0] b);
        return (a > b) ? a - b : b - a;
    endfunction

    logic [P-1:0][P-1:0] hit;

    for (genvar i = 0; i < P; i++) begin : g_row
        for (genvar j = 0; j < P; j++) begin : g_col
            if (i == j) begin : g_self
                assign hit[i][j] = 1'b0;
            end else begin : g_pair
                localparam bit J_FIRST = (j < i);
                logic near;
                logic wins;
                // Both coordinates inside their inclusive windows.
                assign near = (dist_phi(pool_p[j*PHI_W +: PHI_W], pool_p[i*PHI_W +: PHI_W]) <= win_phi)
                           && (dist_theta(pool_t[j*THETA_W +: THETA_W], pool_t[i*THETA_W +: THETA_W]) <= win_theta);
                // Entry j takes precedence over entry i.
                assign wins = (pool_r[j*RANK_W +: RANK_W] > pool_r[i*RANK_W +: RANK_W])
                           || (J_FIRST && (pool_r[j*RANK_W +: RANK_W] == pool_r[i*RANK_W +: RANK_W]));
                assign hit[i][j] = pool_v[j] && near && wins;
            end
        end
        assign alive[i] = pool_v[i] && !(|hit[i]);
    end
endmodule

// File: rtl/tsel_pick.sv
// Parallel top-K selection. Each eligible entry counts the eligible entries
// that precede it; that count is its output slot. Counts at or above the
// active slot limit are not selected. Assumes K <= P.
module tsel_pick #(
    parameter int P      = 18,
    parameter int RANK_W = 6,
    parameter int K      = 3
) (
    input  logic [P-1:0]          elig,
    input  logic [P*RANK_W-1:0]   pool_r,
    input  logic                  mode_single,
    output logic [K-1:0][P-1:0]   sel
);
    localparam int CW = $clog2(P + 1);

    for (genvar i = 0; i < P; i++) begin : g_ent
        logic [P-1:0]  ahead;
        logic [CW-1:0] place;

        for (genvar j = 0; j < P; j++) begin : g_cmp
            if (i == j) begin : g_self
                assign ahead[j] = 1'b0;
            end else begin : g_other
                localparam bit J_FIRST = (j < i);
                assign ahead[j] = elig[j]
                    && ((pool_r[j*RANK_W +: RANK_W] > pool_r[i*RANK_W +: RANK_W])
                     || (J_FIRST && (pool_r[j*RANK_W +: RANK_W] == pool_r[i*RANK_W +: RANK_W])));
            end
        end

        // Position of this entry among the eligible ones.
        always_comb begin
            place = '0;
            for (int j = 0; j < P; j++) begin
                place = place + CW'(ahead[j]);
            end
        end

        for (genvar k = 0; k < K; k++) begin : g_slot
            if (k == 0) begin : g_first
                assign sel[k][i] = elig[i] && (place == CW'(0));
            end else begin : g_rest
                assign sel[k][i] = elig[i] && !mode_single && (place == CW'(k));
            end
        end
    end
endmodule

// File: rtl/ghost_track_selector.sv
// Ranked track selector with ghost cancellation over three crossings.
// Builds the candidate pool, cancels duplicates, picks the best survivors
// not yet retired, and registers them into the output slots (latency 1).
// Assumes N_CAND >= 2 and 1 <= N_OUT <= CROSSINGS*N_CAND.
module ghost_track_selector
    import tsel_pkg::*;
#(
    parameter int N_CAND  = 6,
    parameter int RANK_W  = 6,
    parameter int PHI_W   = 8,
    parameter int THETA_W = 8,
    parameter int N_OUT   = 3
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              mode_single,
    input  logic [PHI_W-1:0]                  win_phi,
    input  logic [THETA_W-1:0]                win_theta,
    input  logic [N_CAND-1:0]                 in_valid,
    input  logic [N_CAND*RANK_W-1:0]          in_rank,
    input  logic [N_CAND*PHI_W-1:0]           in_phi,
    input  logic [N_CAND*THETA_W-1:0]         in_theta,
    output logic [N_OUT-1:0]                  out_valid,
    output logic [N_OUT*RANK_W-1:0]           out_rank,
    output logic [N_OUT*PHI_W-1:0]            out_phi,
    output logic [N_OUT*THETA_W-1:0]          out_theta,
    output logic [N_OUT*AGE_W-1:0]            out_age,
    output logic [N_OUT*$clog2(N_CAND)-1:0]   out_idx
);
    localparam int P     = CROSSINGS * N_CAND;
    localparam int HN    = (CROSSINGS - 1) * N_CAND;
    localparam int IDX_W = $clog2(N_CAND);

    logic [P-1:0]           pool_v;
    logic [P-1:0]           pool_done;
    logic [P*RANK_W-1:0]    pool_r;
    logic [P*PHI_W-1:0]     pool_p;
    logic [P*THETA_W-1:0]   pool_t;
    logic [P-1:0]           alive;
    logic [P-1:0]           elig;
    logic [N_OUT-1:0][P-1:0] sel;
    logic [HN-1:0]          retire_lo;

    logic [N_OUT-1:0]              nx_v;
    logic [N_OUT-1:0][RANK_W-1:0]  nx_r;
    logic [N_OUT-1:0][PHI_W-1:0]   nx_p;
    logic [N_OUT-1:0][THETA_W-1:0] nx_t;
    logic [N_OUT-1:0][AGE_W-1:0]   nx_a;
    logic [N_OUT-1:0][IDX_W-1:0]   nx_i;

    logic [N_OUT-1:0]              q_v;
    logic [N_OUT-1:0][RANK_W-1:0]  q_r;
    logic [N_OUT-1:0][PHI_W-1:0]   q_p;
    logic [N_OUT-1:0][THETA_W-1:0] q_t;
    logic [N_OUT-1:0][AGE_W-1:0]   q_a;
    logic [N_OUT-1:0][IDX_W-1:0]   q_i;

    tsel_history #(
        .N_CAND(N_CAND), .RANK_W(RANK_W), .PHI_W(PHI_W), .THETA_W(THETA_W)
    ) u_hist (
        .clk(clk), .rst_n(rst_n),
        .cur_v(in_valid), .cur_r(in_rank), .cur_p(in_phi), .cur_t(in_theta),
        .retire_lo(retire_lo),
        .pool_v(pool_v), .pool_done(pool_done),
        .pool_r(pool_r), .pool_p(pool_p), .pool_t(pool_t)
    );

    tsel_cancel #(
        .P(P), .RANK_W(RANK_W), .PHI_W(PHI_W), .THETA_W(THETA_W)
    ) u_cancel (
        .pool_v(pool_v), .pool_r(pool_r), .pool_p(pool_p), .pool_t(pool_t),
        .win_phi(win_phi), .win_theta(win_theta),
        .alive(alive)
    );

    assign elig = alive & ~pool_done;

    tsel_pick #(
        .P(P), .RANK_W(RANK_W), .K(N_OUT)
    ) u_pick (
        .elig(elig), .pool_r(pool_r), .mode_single(mode_single),
        .sel(sel)
    );

    // Entries that move on are retired if cancelled now or reported now.
    always_comb begin
        for (int p = 0; p < HN; p++) begin
            retire_lo[p] = !alive[p];
            for (int k = 0; k < N_OUT; k++) begin
                retire_lo[p] = retire_lo[p] | sel[k][p];
            end
        end
    end

    // Gather the fields of the one-hot selected entry for every slot.
    always_comb begin
        for (int k = 0; k < N_OUT; k++) begin
            nx_v[k] = |sel[k];
            nx_r[k] = '0;
            nx_p[k] = '0;
            nx_t[k] = '0;
            nx_a[k] = '0;
            nx_i[k] = '0;
            for (int p = 0; p < P; p++) begin
                if (sel[k][p]) begin
                    nx_r[k] = nx_r[k] | pool_r[p*RANK_W +: RANK_W];
                    nx_p[k] = nx_p[k] | pool_p[p*PHI_W +: PHI_W];
                    nx_t[k] = nx_t[k] | pool_t[p*THETA_W +: THETA_W];
                    nx_a[k] = nx_a[k] | AGE_W'(p / N_CAND);
                    nx_i[k] = nx_i[k] | IDX_W'(p % N_CAND);
                end
            end
        end
    end

    // Output register stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_v <= '0;
            q_r <= '0;
            q_p <= '0;
            q_t <= '0;
            q_a <= '0;
            q_i <= '0;
        end else begin
            q_v <= nx_v;
            q_r <= nx_r;
            q_p <= nx_p;
            q_t <= nx_t;
            q_a <= nx_a;
            q_i <= nx_i;
        end
    end

    assign out_valid = q_v;
    assign out_rank  = q_r;
    assign out_phi   = q_p;
    assign out_theta = q_t;
    assign out_age   = q_a;
    assign out_idx   = q_i;
endmodule

// File: rtl/tsel_checker.sv
// Protocol checker for ghost_track_selector, attached by bind.
// Observes only the top-level ports.
module tsel_checker #(
    parameter int N_CAND = 6,
    parameter int RANK_W = 6,
    parameter int N_OUT  = 3,
    parameter int IDX_W  = 3
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     mode_single,
    input logic [N_OUT-1:0]         out_valid,
    input logic [N_OUT*RANK_W-1:0]  out_rank,
    input logic [N_OUT*2-1:0]       out_age,
    input logic [N_OUT*IDX_W-1:0]   out_idx
);
    // R1: a reset edge leaves every slot empty.
    a_r1_reset_clears: assert property (@(posedge clk) !rst_n |=> out_valid == '0);

    // R8: with the single mode sampled, only slot 0 may carry a candidate.
    if (N_OUT > 1) begin : g_multi
        a_r8_single_slot: assert property (@(posedge clk) disable iff (!rst_n)
            $past(mode_single) |-> out_valid[N_OUT-1:1] == '0);
    end

    for (genvar k = 0; k + 1 < N_OUT; k++) begin : g_adj
        // R3: slots are filled from slot 0 upward.
        a_r3_fill_order: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid[k+1] |-> out_valid[k]);

        // R2: neighbouring slots are in strict precedence order.
        a_r2_order: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid[k] && out_valid[k+1]) |->
                ((out_rank[k*RANK_W +: RANK_W] > out_rank[(k+1)*RANK_W +: RANK_W])
                 || ((out_rank[k*RANK_W +: RANK_W] == out_rank[(k+1)*RANK_W +: RANK_W])
                     && ((int'(out_age[k*2 +: 2]) * N_CAND + int'(out_idx[k*IDX_W +: IDX_W]))
                         < (int'(out_age[(k+1)*2 +: 2]) * N_CAND + int'(out_idx[(k+1)*IDX_W +: IDX_W]))))));
    end

    // R7: a reported candidate does not reappear one crossing later.
    for (genvar k = 0; k < N_OUT; k++) begin : g_src
        for (genvar m = 0; m < N_OUT; m++) begin : g_dst
            a_r7_no_repeat: assert property (@(posedge clk) disable iff (!rst_n)
                (out_valid[k] && (out_age[k*2 +: 2] != 2'd2)) |=>
                    !(out_valid[m]
                      && (out_age[m*2 +: 2] == $past(out_age[k*2 +: 2]) + 2'd1)
                      && (out_idx[m*IDX_W +: IDX_W] == $past(out_idx[k*IDX_W +: IDX_W]))));
        end
    end
endmodule

bind ghost_track_selector tsel_checker #(
    .N_CAND(N_CAND), .RANK_W(RANK_W), .N_OUT(N_OUT), .IDX_W($clog2(N_CAND))
) u_tsel_chk (
    .clk(clk), .rst_n(rst_n), .mode_single(mode_single),
    .out_valid(out_valid), .out_rank(out_rank),
    .out_age(out_age), .out_idx(out_idx)
);

// File: tb/tb_ghost_track_selector.sv
module tb_ghost_track_selector;
    localparam int CLK_PERIOD = 10;
    localparam int N_CAND  = 6;
    localparam int RANK_W  = 6;
    localparam int PHI_W   = 8;
    localparam int THETA_W = 8;
    localparam int N_OUT   = 3;
    localparam int IDX_W   = 3;
    localparam int NV      = 14;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_single = 1'b0;
    logic [PHI_W-1:0] win_phi = 8'd4;
    logic [THETA_W-1:0] win_theta = 8'd3;
    logic [N_CAND-1:0] in_valid = '0;
    logic [N_CAND*RANK_W-1:0] in_rank = '0;
    logic [N_CAND*PHI_W-1:0] in_phi = '0;
    logic [N_CAND*THETA_W-1:0] in_theta = '0;
    logic [N_OUT-1:0] out_valid;
    logic [N_OUT*RANK_W-1:0] out_rank;
    logic [N_OUT*PHI_W-1:0] out_phi;
    logic [N_OUT*THETA_W-1:0] out_theta;
    logic [N_OUT*2-1:0] out_age;
    logic [N_OUT*IDX_W-1:0] out_idx;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    ghost_track_selector #(
        .N_CAND(N_CAND), .RANK_W(RANK_W), .PHI_W(PHI_W), .THETA_W(THETA_W), .N_OUT(N_OUT)
    ) dut (
        .clk(clk), .rst_n(rst_n), .mode_single(mode_single),
        .win_phi(win_phi), .win_theta(win_theta),
        .in_valid(in_valid), .in_rank(in_rank), .in_phi(in_phi), .in_theta(in_theta),
        .out_valid(out_valid), .out_rank(out_rank), .out_phi(out_phi),
        .out_theta(out_theta), .out_age(out_age), .out_idx(out_idx)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // One table row: mode, three input candidates (rank 0 = absent),
    // three expected slots (rank 0 = slot empty).
    typedef struct packed {
        logic            single;
        logic [2:0][7:0] cr;
        logic [2:0][7:0] cp;
        logic [2:0][7:0] ct;
        logic [2:0][7:0] er;
        logic [2:0][1:0] ea;
        logic [2:0][2:0] ei;
    } vec_t;

    function automatic vec_t mkv(input int s,
        input int r0, input int p0, input int t0,
        input int r1, input int p1, input int t1,
        input int r2, input int p2, input int t2,
        input int x0, input int a0, input int i0,
        input int x1, input int a1, input int i1,
        input int x2, input int a2, input int i2);
        vec_t v;
        v.single = 1'(s);
        v.cr[0] = 8'(r0); v.cp[0] = 8'(p0); v.ct[0] = 8'(t0);
        v.cr[1] = 8'(r1); v.cp[1] = 8'(p1); v.ct[1] = 8'(t1);
        v.cr[2] = 8'(r2); v.cp[2] = 8'(p2); v.ct[2] = 8'(t2);
        v.er[0] = 8'(x0); v.ea[0] = 2'(a0); v.ei[0] = 3'(i0);
        v.er[1] = 8'(x1); v.ea[1] = 2'(a1); v.ei[1] = 3'(i1);
        v.er[2] = 8'(x2); v.ea[2] = 2'(a2); v.ei[2] = 3'(i2);
        return v;
    endfunction

    // Windows are 4 (azimuth) and 3 (polar) while the table runs.
    localparam vec_t TBL [NV] = '{
        mkv(0, 10,10,10, 20,50,20, 5,100,40,    20,0,1, 10,0,0, 5,0,2),
        mkv(0, 0,0,0, 0,0,0, 0,0,0,              0,0,0, 0,0,0, 0,0,0),
        mkv(0, 0,0,0, 0,0,0, 0,0,0,              0,0,0, 0,0,0, 0,0,0),
        mkv(0, 0,0,0, 0,0,0, 0,0,0,              0,0,0, 0,0,0, 0,0,0),
        mkv(0, 30,200,100, 25,203,102, 8,204,120, 30,0,0, 8,0,2, 0,0,0),
        mkv(0, 28,201,99, 40,10,200, 0,0,0,      40,0,1, 0,0,0, 0,0,0),
        mkv(0, 12,150,50, 11,154,53, 9,145,46,   12,0,0, 9,0,2, 0,0,0),
        mkv(0, 15,60,60, 15,62,61, 0,0,0,        15,0,0, 0,0,0, 0,0,0),
        mkv(0, 15,61,60, 0,0,0, 0,0,0,           15,0,0, 0,0,0, 0,0,0),
        mkv(0, 7,30,150, 33,80,150, 7,130,150,   33,0,1, 7,0,0, 7,0,2),
        mkv(1, 20,10,30, 22,40,30, 21,70,30,     22,0,1, 0,0,0, 0,0,0),
        mkv(0, 0,0,0, 0,0,0, 0,0,0,              21,1,2, 20,1,0, 0,0,0),
        mkv(0, 0,0,0, 0,0,0, 0,0,0,              0,0,0, 0,0,0, 0,0,0),
        mkv(1, 0,0,0, 0,0,0, 0,0,0,              0,0,0, 0,0,0, 0,0,0)
    };
    localparam string TAG [NV] = '{"R2", "R7", "R7", "R6", "R4", "R7", "R4",
                                   "R5", "R5", "R2", "R8", "R6", "R7", "R8"};

    task automatic clear_in();
        in_valid = '0;
        in_rank  = '0;
        in_phi   = '0;
        in_theta = '0;
    endtask

    task automatic put(input int k, input int r, input int p, input int t);
        in_valid[k] = 1'b1;
        in_rank[k*RANK_W +: RANK_W]   = RANK_W'(r);
        in_phi[k*PHI_W +: PHI_W]      = PHI_W'(p);
        in_theta[k*THETA_W +: THETA_W] = THETA_W'(t);
    endtask

    // Present the crossing at the next edge, then sample after it.
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // Compare one output slot; er == 0 means the slot must be empty.
    task automatic chk_slot(input string tag, input int k, input int er, input int ea, input int ei);
        int gv, gr, ga, gi;
        gv = int'(out_valid[k]);
        gr = int'(out_rank[k*RANK_W +: RANK_W]);
        ga = int'(out_age[k*2 +: 2]);
        gi = int'(out_idx[k*IDX_W +: IDX_W]);
        checks++;
        if (er == 0) begin
            if (gv != 0) begin
                errors++;
                $display("FAIL %s/R3 slot %0d: valid=%0d rank=%0d, expected empty", tag, k, gv, gr);
            end
        end else if (gv != 1 || gr != er || ga != ea || gi != ei) begin
            errors++;
            $display("FAIL %s/R9 slot %0d: got v=%0d rank=%0d age=%0d idx=%0d, expected v=1 rank=%0d age=%0d idx=%0d",
                     tag, k, gv, gr, ga, gi, er, ea, ei);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout, expected completion");
        finish_run();
    end

    initial begin
        // R1: outputs are empty while held in reset.
        step();
        step();
        for (int k = 0; k < N_OUT; k++) chk_slot("R1", k, 0, 0, 0);
        rst_n = 1'b1;

        // Table walk.
        for (int v = 0; v < NV; v++) begin
            clear_in();
            mode_single = TBL[v].single;
            for (int k = 0; k < 3; k++) begin
                if (TBL[v].cr[k] != 0) put(k, int'(TBL[v].cr[k]), int'(TBL[v].cp[k]), int'(TBL[v].ct[k]));
            end
            step();
            for (int k = 0; k < N_OUT; k++) begin
                chk_slot(TAG[v], k, int'(TBL[v].er[k]), int'(TBL[v].ea[k]), int'(TBL[v].ei[k]));
            end
        end

        // R8 and R6: every input position, single mode, leftovers age out.
        clear_in();
        mode_single = 1'b1;
        for (int k = 0; k < N_CAND; k++) put(k, k + 1, 20 + 40 * k, 240);
        step();
        chk_slot("R8", 0, 6, 0, 5);
        chk_slot("R8", 1, 0, 0, 0);
        checks++;
        if (out_phi[PHI_W-1:0] != 8'd220 || out_theta[THETA_W-1:0] != 8'd240) begin
            errors++;
            $display("FAIL R9 coords: got phi=%0d theta=%0d, expected phi=220 theta=240",
                     out_phi[PHI_W-1:0], out_theta[THETA_W-1:0]);
        end
        clear_in();
        step();
        chk_slot("R8", 0, 5, 1, 4);
        chk_slot("R8", 1, 0, 0, 0);
        mode_single = 1'b0;
        step();
        chk_slot("R6", 0, 4, 2, 3);
        chk_slot("R6", 1, 3, 2, 2);
        chk_slot("R6", 2, 2, 2, 1);
        step();
        for (int k = 0; k < N_OUT; k++) chk_slot("R6", k, 0, 0, 0);

        // R4: zero windows cancel only identical coordinates.
        win_phi = '0;
        win_theta = '0;
        put(0, 9, 100, 5);
        put(1, 3, 100, 5);
        put(2, 4, 101, 5);
        step();
        chk_slot("R4", 0, 9, 0, 0);
        chk_slot("R4", 1, 4, 0, 2);
        chk_slot("R4", 2, 0, 0, 0);
        win_phi = 8'd4;
        win_theta = 8'd3;

        // R1: reset mid-run discards an unreported candidate.
        clear_in();
        mode_single = 1'b1;
        put(0, 5, 10, 10);
        put(1, 6, 50, 10);
        step();
        chk_slot("R8", 0, 6, 0, 1);
        clear_in();
        mode_single = 1'b0;
        rst_n = 1'b0;
        step();
        for (int k = 0; k < N_OUT; k++) chk_slot("R1", k, 0, 0, 0);
        rst_n = 1'b1;
        step();
        for (int k = 0; k < N_OUT; k++) chk_slot("R1", k, 0, 0, 0);

        finish_run();
    end
endmodule